// File: doc/BRIEF.md
# Timed Non-Volatile Slot Store with Ready/Busy Line

This block stands in for the non-volatile word store behind a serially controlled dual digital potentiometer. It holds a small array of 9-bit words, four slots for each of two channels, in registers. Bits 7..0 of a word are a wiper tap value and bit 8 is the output-buffer mode. A command controller hands it one request at a time: an operation code, a channel, a slot and 9-bit data. The block erases, programs, reads or recalls the addressed word. It returns read data with a one-cycle done pulse and drives a ready/busy line that external hosts poll.

Operations that touch the slow store hold the ready line low for a fixed store time, counted in system clocks by the parameter STORE_CYCLES. A request that arrives while the store is still busy is refused with a reject pulse. An erase sets the whole word to ones, and a program can only clear bits. The write-protect input, active low, freezes the array while reads and recalls still go through. After reset, slot 0 of every channel is recalled on its own, so the channel tap registers start from their saved setting. The reset contents of the array come from the parameter INIT_WORDS.

Top module: `nvslot_store`

## Requirements
- R1: After reset release the recall port pulses once per channel on consecutive cycles, channel 0 first, each carrying that channel's slot 0 word. The ready line is high and done, reject and recall-valid are low during reset.
- R2: Read-slot (op code 2) returns the addressed word on rd_data_o, with done_o high, on the cycle after the request is accepted. The word index is channel*4+slot.
- R3: Erase (op code 6) sets the addressed 9-bit word to 0x1FF.
- R4: Program (op code 3) stores the bitwise AND of the old word and req_data_i, so a slot that was not erased can only lose set bits.
- R5: While wp_n_i is low, erase, program and program-from-tap leave the array unchanged, but read-slot and recall still return stored words.
- R6: Recall (op code 4) presents the addressed word on the recall port with the requested channel, with recall_vld_o high for one cycle.
- R7: Program-from-tap (op code 5) writes req_data_i, the current tap setting, into the slot with the same AND rule as program.
- R8: Op codes 1 to 5 drive ready_o low for exactly STORE_CYCLES cycles, starting the cycle after acceptance, and then release it high.
- R9: Erase and the no-effect op codes 0 and 7 give a done pulse and leave ready_o high.
- R10: A request that arrives while the store timer runs, or during the power-up recall, gives a reject pulse and no done pulse, and it leaves the array unchanged.
- R11: sel_start_i drives ready_o high on the next cycle. This wins over a busy start in the same cycle, and the store timer keeps running, so requests are still refused until it expires.
- R12: Read-tap (op code 1) echoes req_data_i on rd_data_o with a done pulse and a store-time busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_start_i | input | 1 | One-cycle pulse: chip select of a new frame fell |
| wp_n_i | input | 1 | Write protect, active low |
| req_vld_i | input | 1 | Request valid for one cycle |
| req_op_i | input | 3 | Operation code |
| req_ch_i | input | CW (1) | Channel address |
| req_slot_i | input | SW (2) | Slot address |
| req_data_i | input | WW (9) | Data word or tap setting |
| done_o | output | 1 | Request accepted and carried out |
| rej_o | output | 1 | Request refused because the store was busy |
| rd_data_o | output | WW (9) | Read result, held until the next read |
| recall_vld_o | output | 1 | Recall word valid for one cycle |
| recall_ch_o | output | CW (1) | Channel the recall word is for |
| recall_data_o | output | WW (9) | Recalled word |
| ready_o | output | 1 | Ready/busy line, low while busy |

## Verification
Two things can land on the ready line in the same cycle: the frame-start pulse and the acceptance of a timed operation. The bench provokes this by pulsing sel_start_i in the very cycle a read request is taken. It judges the result by ready_o being high on the next sample while a request one cycle later is still refused. A second collision puts a request right after a busy start. It is judged by the reject pulse, by the absence of a done pulse, and by a later read showing the slot unchanged.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_RD_TAP   = 3'd1,
        OP_RD_SLOT  = 3'd2,
        OP_PROG     = 3'd3,
        OP_RECALL   = 3'd4,
        OP_PROG_TAP = 3'd5,
        OP_ERASE    = 3'd6,
        OP_SPARE    = 3'd7
    } nvs_op_e;

    // operations that occupy the slow store and drop the ready line
    function automatic logic op_is_timed(nvs_op_e op);
        return (op == OP_RD_TAP) || (op == OP_RD_SLOT) || (op == OP_PROG) ||
               (op == OP_RECALL) || (op == OP_PROG_TAP);
    endfunction

    // operations that alter the array
    function automatic logic op_is_write(nvs_op_e op);
        return (op == OP_PROG) || (op == OP_PROG_TAP) || (op == OP_ERASE);
    endfunction

endpackage

// File: rtl/nvs_word_array.sv
module nvs_word_array #(
    parameter int NWORD = 8,
    parameter int WW    = 9,
    parameter int IW    = 3,
    parameter logic [NWORD*WW-1:0] INIT_WORDS = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [WW-1:0] wr_word,
    input  logic [IW-1:0] rd_idx,
    output logic [WW-1:0] rd_word
);

    logic [WW-1:0] mem_d [NWORD];
    logic [WW-1:0] mem_q [NWORD];

    always_comb begin
        for (int i = 0; i < NWORD; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            for (int i = 0; i < NWORD; i++) begin
                if (wr_idx == IW'(i)) begin
                    mem_d[i] = wr_word;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORD; i++) begin
                mem_q[i] <= INIT_WORDS[i*WW +: WW];
            end
        end else begin
            for (int i = 0; i < NWORD; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NWORD; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_word = mem_q[i];
            end
        end
    end

endmodule

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer #(
    parameter int STORE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sel_start,
    output logic busy,
    output logic ready
);

    localparam int TW = (STORE_CYCLES > 1) ? $clog2(STORE_CYCLES) : 1;
    localparam logic [TW-1:0] LOAD = TW'(STORE_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic          ready;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                t_d.busy  = 1'b0;
                t_d.ready = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end
        if (start) begin
            t_d.busy  = 1'b1;
            t_d.cnt   = LOAD;
            t_d.ready = 1'b0;
        end
        // a new frame always raises the line; the timer is left running
        if (sel_start) begin
            t_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{busy: 1'b0, ready: 1'b1, cnt: '0};
        end else begin
            t_q <= t_d;
        end
    end

    assign busy  = t_q.busy;
    assign ready = t_q.ready;

endmodule

// File: rtl/nvslot_store.sv
module nvslot_store
    import nvs_pkg::*;
#(
    parameter int NCH          = 2,
    parameter int NSLOT        = 4,
    parameter int WW           = 9,
    parameter int STORE_CYCLES = 16,
    parameter int CW           = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int SW           = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    parameter logic [NCH*NSLOT*WW-1:0] INIT_WORDS =
        {9'h1FF, 9'h055, 9'h000, 9'h13C, 9'h1FF, 9'h0F0, 9'h1A5, 9'h080}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_start_i,
    input  logic          wp_n_i,
    input  logic          req_vld_i,
    input  logic [2:0]    req_op_i,
    input  logic [CW-1:0] req_ch_i,
    input  logic [SW-1:0] req_slot_i,
    input  logic [WW-1:0] req_data_i,
    output logic          done_o,
    output logic          rej_o,
    output logic [WW-1:0] rd_data_o,
    output logic          recall_vld_o,
    output logic [CW-1:0] recall_ch_o,
    output logic [WW-1:0] recall_data_o,
    output logic          ready_o
);

    localparam int NWORD = NCH * NSLOT;
    localparam int IW    = (NWORD > 1) ? $clog2(NWORD) : 1;
    localparam int BW    = CW + 1;
    localparam logic [BW-1:0] BOOT_END = BW'(NCH);

    typedef struct packed {
        logic          done;
        logic          rej;
        logic [WW-1:0] rd_data;
        logic          rc_vld;
        logic [CW-1:0] rc_ch;
        logic [WW-1:0] rc_data;
        logic [BW-1:0] boot;
    } ctl_t;

    ctl_t c_d, c_q;

    nvs_op_e       op;
    logic          boot_act;
    logic          busy;
    logic          accept;
    logic          tmr_start;
    logic          wr_en;
    logic [IW-1:0] req_idx;
    logic [IW-1:0] rd_idx;
    logic [WW-1:0] wr_word;
    logic [WW-1:0] word;

    assign op       = nvs_op_e'(req_op_i);
    assign boot_act = (c_q.boot < BOOT_END);
    assign req_idx  = IW'(req_ch_i) * IW'(NSLOT) + IW'(req_slot_i);
    assign rd_idx   = boot_act ? IW'(c_q.boot) * IW'(NSLOT) : req_idx;
    assign accept   = req_vld_i && !boot_act && !busy;
    assign tmr_start = accept && op_is_timed(op);
    assign wr_en    = accept && wp_n_i && op_is_write(op);
    assign wr_word  = (op == OP_ERASE) ? {WW{1'b1}} : (word & req_data_i);

    nvs_word_array #(
        .NWORD(NWORD), .WW(WW), .IW(IW), .INIT_WORDS(INIT_WORDS)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(req_idx), .wr_word(wr_word),
        .rd_idx(rd_idx), .rd_word(word)
    );

    nvs_busy_timer #(.STORE_CYCLES(STORE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start(tmr_start), .sel_start(sel_start_i),
        .busy(busy), .ready(ready_o)
    );

    always_comb begin
        c_d        = c_q;
        c_d.done   = accept;
        c_d.rej    = req_vld_i && !accept;
        c_d.rc_vld = 1'b0;
        if (boot_act) begin
            c_d.rc_vld  = 1'b1;
            c_d.rc_ch   = c_q.boot[CW-1:0];
            c_d.rc_data = word;
            c_d.boot    = c_q.boot + 1'b1;
        end else if (accept) begin
            case (op)
                OP_RD_SLOT: c_d.rd_data = word;
                OP_RD_TAP:  c_d.rd_data = req_data_i;
                OP_RECALL: begin
                    c_d.rc_vld  = 1'b1;
                    c_d.rc_ch   = req_ch_i;
                    c_d.rc_data = word;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign done_o        = c_q.done;
    assign rej_o         = c_q.rej;
    assign rd_data_o     = c_q.rd_data;
    assign recall_vld_o  = c_q.rc_vld;
    assign recall_ch_o   = c_q.rc_ch;
    assign recall_data_o = c_q.rc_data;

endmodule

// File: rtl/nvs_store_chk.sv
module nvs_store_chk #(
    parameter int STORE_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_start_i,
    input logic       req_vld_i,
    input logic [2:0] req_op_i,
    input logic       done_o,
    input logic       rej_o,
    input logic       ready_o
);

    int low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= 0;
        end else if (!ready_o) begin
            low_run <= low_run + 1;
        end else begin
            low_run <= 0;
        end
    end

    // R10
    rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej_o |-> !done_o);

    // R11
    sel_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_start_i |=> ready_o);

    // R8
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> ($past(req_vld_i) && !$past(sel_start_i)));

    // R8
    ready_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= STORE_CYCLES);

    // R9
    erase_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ($past(req_op_i) == 3'd6)) |-> ready_o);

endmodule

bind nvslot_store nvs_store_chk #(.STORE_CYCLES(STORE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_start_i(sel_start_i),
    .req_vld_i(req_vld_i), .req_op_i(req_op_i),
    .done_o(done_o), .rej_o(rej_o), .ready_o(ready_o)
);

// File: tb/sim_nvslot_store.sv
`timescale 1ns/1ps
module sim_nvslot_store;

    localparam int S = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_start_i = 1'b0;
    logic       wp_n_i = 1'b1;
    logic       req_vld_i = 1'b0;
    logic [2:0] req_op_i = 3'd0;
    logic [0:0] req_ch_i = 1'b0;
    logic [1:0] req_slot_i = 2'd0;
    logic [8:0] req_data_i = 9'd0;
    logic       done_o, rej_o, recall_vld_o, ready_o;
    logic [8:0] rd_data_o, recall_data_o;
    logic [0:0] recall_ch_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nvslot_store #(.STORE_CYCLES(S)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_start_i(sel_start_i), .wp_n_i(wp_n_i),
        .req_vld_i(req_vld_i), .req_op_i(req_op_i), .req_ch_i(req_ch_i),
        .req_slot_i(req_slot_i), .req_data_i(req_data_i),
        .done_o(done_o), .rej_o(rej_o), .rd_data_o(rd_data_o),
        .recall_vld_o(recall_vld_o), .recall_ch_o(recall_ch_o),
        .recall_data_o(recall_data_o), .ready_o(ready_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // drive one request at a falling edge, sample after the next rising edge
    task automatic issue(input logic [2:0] op, input logic ch, input logic [1:0] sl,
                         input logic [8:0] dat, input logic sel);
        req_vld_i = 1'b1; req_op_i = op; req_ch_i = ch; req_slot_i = sl;
        req_data_i = dat; sel_start_i = sel;
        @(negedge clk);
        req_vld_i = 1'b0; sel_start_i = 1'b0;
    endtask

    task automatic wait_ready(output int lows);
        lows = 0;
        while (!ready_o) begin
            lows++;
            @(negedge clk);
        end
    endtask

    task automatic read_word(input logic ch, input logic [1:0] sl, input logic [8:0] exp,
                             input string tag);
        int lows;
        issue(3'd2, ch, sl, 9'd0, 1'b0);
        check(tag, rd_data_o, exp);
        wait_ready(lows);
    endtask

    task automatic t_boot;
        check("R1 reset ready", ready_o, 1);
        check("R1 reset done", done_o, 0);
        check("R1 reset rej", rej_o, 0);
        check("R1 reset recall", recall_vld_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 boot0 vld", recall_vld_o, 1);
        check("R1 boot0 ch", recall_ch_o, 0);
        check("R1 boot0 data", recall_data_o, 9'h080);
        @(negedge clk);
        check("R1 boot1 vld", recall_vld_o, 1);
        check("R1 boot1 ch", recall_ch_o, 1);
        check("R1 boot1 data", recall_data_o, 9'h13C);
        @(negedge clk);
        check("R1 boot end", recall_vld_o, 0);
        check("R1 boot ready", ready_o, 1);
    endtask

    task automatic t_read;
        int lows;
        issue(3'd2, 1'b0, 2'd1, 9'd0, 1'b0);
        check("R2 done", done_o, 1);
        check("R2 data ch0 s1", rd_data_o, 9'h1A5);
        wait_ready(lows);
        check("R8 low length", lows, S);
        read_word(1'b1, 2'd2, 9'h055, "R2 data ch1 s2");
    endtask

    task automatic t_erase_prog;
        int lows;
        issue(3'd6, 1'b0, 2'd2, 9'd0, 1'b0);
        check("R9 erase done", done_o, 1);
        check("R9 erase ready", ready_o, 1);
        @(negedge clk);
        check("R9 erase ready later", ready_o, 1);
        read_word(1'b0, 2'd2, 9'h1FF, "R3 erased word");
        issue(3'd3, 1'b0, 2'd2, 9'h0C3, 1'b0);
        wait_ready(lows);
        check("R8 program low length", lows, S);
        read_word(1'b0, 2'd2, 9'h0C3, "R4 program erased");
        issue(3'd3, 1'b0, 2'd1, 9'h0FF, 1'b0);
        wait_ready(lows);
        read_word(1'b0, 2'd1, 9'h0A5, "R4 program unerased AND");
    endtask

    task automatic t_wp;
        int lows;
        wp_n_i = 1'b0;
        issue(3'd6, 1'b1, 2'd0, 9'd0, 1'b0);
        read_word(1'b1, 2'd0, 9'h13C, "R5 erase blocked");
        issue(3'd3, 1'b1, 2'd3, 9'h000, 1'b0);
        wait_ready(lows);
        issue(3'd5, 1'b1, 2'd3, 9'h000, 1'b0);
        wait_ready(lows);
        read_word(1'b1, 2'd3, 9'h1FF, "R5 program blocked");
        issue(3'd4, 1'b1, 2'd0, 9'd0, 1'b0);
        check("R5 recall under protect", recall_data_o, 9'h13C);
        wait_ready(lows);
        wp_n_i = 1'b1;
    endtask

    task automatic t_recall;
        int lows;
        issue(3'd4, 1'b1, 2'd2, 9'd0, 1'b0);
        check("R6 recall vld", recall_vld_o, 1);
        check("R6 recall ch", recall_ch_o, 1);
        check("R6 recall data", recall_data_o, 9'h055);
        @(negedge clk);
        check("R6 recall single pulse", recall_vld_o, 0);
        wait_ready(lows);
        check("R8 recall low length", lows, S - 1);
    endtask

    task automatic t_prog_tap;
        int lows;
        issue(3'd5, 1'b1, 2'd3, 9'h17E, 1'b0);
        check("R7 done", done_o, 1);
        wait_ready(lows);
        read_word(1'b1, 2'd3, 9'h17E, "R7 tap stored");
    endtask

    task automatic t_rdtap;
        int lows;
        issue(3'd1, 1'b0, 2'd0, 9'h15A, 1'b0);
        check("R12 echo", rd_data_o, 9'h15A);
        check("R12 done", done_o, 1);
        wait_ready(lows);
        check("R12 busy length", lows, S);
    endtask

    task automatic t_reject;
        int lows;
        issue(3'd2, 1'b0, 2'd0, 9'd0, 1'b0);
        issue(3'd3, 1'b0, 2'd3, 9'h000, 1'b0);
        check("R10 reject pulse", rej_o, 1);
        check("R10 no done", done_o, 0);
        wait_ready(lows);
        read_word(1'b0, 2'd3, 9'h1FF, "R10 word unchanged");
    endtask

    task automatic t_sel;
        int lows;
        issue(3'd2, 1'b0, 2'd0, 9'd0, 1'b1);
        check("R11 sel wins ready", ready_o, 1);
        issue(3'd0, 1'b0, 2'd0, 9'd0, 1'b0);
        check("R11 timer still runs", rej_o, 1);
        repeat (S + 2) @(negedge clk);
        issue(3'd2, 1'b0, 2'd0, 9'd0, 1'b0);
        check("R11 accepted after timer", done_o, 1);
        @(negedge clk);
        sel_start_i = 1'b1;
        @(negedge clk);
        sel_start_i = 1'b0;
        check("R11 sel raises busy line", ready_o, 1);
        repeat (S) @(negedge clk);
    endtask

    task automatic t_other;
        issue(3'd0, 1'b0, 2'd0, 9'd0, 1'b0);
        check("R9 other done", done_o, 1);
        check("R9 other ready", ready_o, 1);
        issue(3'd7, 1'b1, 2'd1, 9'd0, 1'b0);
        check("R9 spare ready", ready_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_boot();
        t_read();
        t_erase_prog();
        t_wp();
        t_recall();
        t_prog_tap();
        t_rdtap();
        t_reject();
        t_sel();
        t_other();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule